// File: doc/BRIEF.md
# Multi-slope ratiometric conversion sequencer

This block is the digital controller for a resistance measurement made with an external RC network, one comparator and three analog switches. A pulse on `start` runs a fixed four-phase sequence. The capacitor is charged. It is then discharged through the reference resistor. It is charged again. Finally it is discharged through the sensor resistor. During each discharge the block counts clock cycles until the comparator reports that the capacitor voltage has dropped below its threshold.

The two counts are left on the outputs for software. The sensor resistance equals the reference resistance times the sensor count divided by the reference count. The division and all analog parts lie outside the block. Each charge phase lasts a programmable number of cycles. Only one switch is ever closed at a time, and one cycle with every switch open separates consecutive phases.

The controller is a single state machine with these states: `ST_IDLE`, `ST_CHG1` (first charge), `ST_GAP1`, `ST_DREF` (reference discharge), `ST_GAP2`, `ST_CHG2` (recharge), `ST_GAP3`, `ST_DSNS` (sensor discharge) and `ST_FIN` (done pulse, all switches open). The transitions are as follows:
- `ST_IDLE` goes to `ST_CHG1` on start.
- Each charge state goes to the next gap state when its cycle count expires.
- Each gap state goes to the following phase after one cycle.
- `ST_DREF` goes to `ST_GAP2` on a comparator trip.
- `ST_DSNS` goes to `ST_FIN` on a comparator trip.
- Either discharge state goes to `ST_IDLE` on counter overflow.
- `ST_FIN` goes to `ST_IDLE`.

Top module: `rcratio_seq`

## Requirements
- R1: While reset is applied and just after it, all switch outputs, `busy`, `done` and `overflow` are 0, and both counts are 0.
- R2: A `start` sampled high while idle begins a sequence. `busy` is 1 from the next cycle until the cycle after the done pulse, or until the sequence ends on overflow.
- R3: The phases run in the order charge (`sw_charge`), reference discharge (`sw_ref`), charge (`sw_charge`), sensor discharge (`sw_sense`). At most one switch output is 1 in any cycle.
- R4: A phase never changes directly into another phase. At least one cycle with all three switches at 0 lies between any two different switch phases.
- R5: Each charge phase lasts `charge_len` cycles, and a value of 0 is treated as 1. `charge_len` is captured at start, so changing it later has no effect on the running sequence.
- R6: `ref_count` equals the number of reference-discharge cycles in which `cmp_above` was sampled 1 before the first cycle in which it was sampled 0. That first cycle ends the phase.
- R7: `sense_count` is defined the same way for the sensor-discharge phase. The trip that ends this phase is followed by the done cycle.
- R8: Suppose a count is at its maximum 2^CNT_W-1 and `cmp_above` is still 1. Then `overflow` is set, the sequence returns to idle with all switches open, and no done pulse is given. A trip in the cycle where the count is at maximum is still a valid result. `overflow` holds until the next start clears it.
- R9: `done` is a one-cycle pulse given only when both counts are valid. Both counts are cleared at start and stay stable from their capture until the next start.
- R10: A `start` that arrives while `busy` is 1 is ignored, and the running sequence and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (sampled while idle) |
| charge_len | input | CHG_W | Cycles per charge phase (0 acts as 1) |
| cmp_above | input | 1 | Comparator: 1 while the capacitor voltage is above the threshold |
| sw_charge | output | 1 | Close the charge switch |
| sw_ref | output | 1 | Close the reference-resistor discharge switch |
| sw_sense | output | 1 | Close the sensor-resistor discharge switch |
| ref_count | output | CNT_W | Reference discharge cycle count |
| sense_count | output | CNT_W | Sensor discharge cycle count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: both counts valid |
| overflow | output | 1 | A discharge count reached its maximum without a trip |

## Verification
The hardest situations to reach from the ports are the discharge limits: a trip in exactly the cycle where the count sits at its maximum, and overflow one cycle later, in each of the two discharge phases. The bench uses a narrow counter and a comparator model that follows the discharge switches. The model releases the comparator after a chosen number of discharge cycles. Sweeping that number through small values and through 2^CNT_W-1, 2^CNT_W and beyond reaches both edges in both phases. A start pulse and a change of `charge_len` in mid-sequence cover the ignored-input cases.

// File: rtl/rcratio_pkg.sv
package rcratio_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHG1,
        ST_GAP1,
        ST_DREF,
        ST_GAP2,
        ST_CHG2,
        ST_GAP3,
        ST_DSNS,
        ST_FIN
    } seq_state_t;

    localparam int NUM_DIS = 2;
    localparam int DIS_REF = 0;
    localparam int DIS_SNS = 1;
endpackage

// File: rtl/rcratio_chg_timer.sv
module rcratio_chg_timer #(
    parameter int CHG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CHG_W-1:0] len_in,
    input  logic             run,
    output logic             expire
);
    logic [CHG_W-1:0] len_q;
    logic [CHG_W-1:0] tcnt;
    logic [CHG_W-1:0] last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (load) begin
            len_q <= len_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (!run) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + CHG_W'(1);
        end
    end

    always_comb begin
        last   = (len_q == '0) ? '0 : len_q - CHG_W'(1);
        expire = run && (tcnt == last);
    end
endmodule

// File: rtl/rcratio_dis_count.sv
module rcratio_dis_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             cmp_above,
    output logic [CNT_W-1:0] count,
    output logic             trip,
    output logic             full
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run && cmp_above && !full) begin
            count <= count + CNT_W'(1);
        end
    end

    always_comb begin
        full = (count == MAXV);
        trip = run && !cmp_above;
    end
endmodule

// File: rtl/rcratio_ctrl.sv
module rcratio_ctrl
    import rcratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               chg_expire,
    input  logic [NUM_DIS-1:0] trip,
    input  logic [NUM_DIS-1:0] full,
    output logic               sw_charge,
    output logic               sw_ref,
    output logic               sw_sense,
    output logic               busy,
    output logic               done,
    output logic               overflow,
    output logic               chg_run,
    output logic               chg_load,
    output logic               dis_clear,
    output logic [NUM_DIS-1:0] dis_run
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic       ovf_set;
    logic       launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            overflow <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                overflow <= 1'b0;
            end else if (ovf_set) begin
                overflow <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        ovf_set = 1'b0;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    launch  = 1'b1;
                    state_d = ST_CHG1;
                end
            end
            ST_CHG1: if (chg_expire) state_d = ST_GAP1;
            ST_GAP1: state_d = ST_DREF;
            ST_DREF: begin
                if (trip[DIS_REF]) begin
                    state_d = ST_GAP2;
                end else if (full[DIS_REF]) begin
                    ovf_set = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_GAP2: state_d = ST_CHG2;
            ST_CHG2: if (chg_expire) state_d = ST_GAP3;
            ST_GAP3: state_d = ST_DSNS;
            ST_DSNS: begin
                if (trip[DIS_SNS]) begin
                    state_d = ST_FIN;
                end else if (full[DIS_SNS]) begin
                    ovf_set = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sw_charge = 1'b0;
        sw_ref    = 1'b0;
        sw_sense  = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        dis_run   = '0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_CHG1, ST_CHG2: sw_charge = 1'b1;
            ST_DREF: begin
                sw_ref           = 1'b1;
                dis_run[DIS_REF] = 1'b1;
            end
            ST_DSNS: begin
                sw_sense         = 1'b1;
                dis_run[DIS_SNS] = 1'b1;
            end
            ST_FIN: done = 1'b1;
            ST_GAP1, ST_GAP2, ST_GAP3: ;
            default: busy = 1'b0;
        endcase
        chg_run   = sw_charge;
        chg_load  = launch;
        dis_clear = launch;
    end
endmodule

// File: rtl/rcratio_seq.sv
module rcratio_seq
    import rcratio_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CHG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CHG_W-1:0] charge_len,
    input  logic             cmp_above,
    output logic             sw_charge,
    output logic             sw_ref,
    output logic             sw_sense,
    output logic [CNT_W-1:0] ref_count,
    output logic [CNT_W-1:0] sense_count,
    output logic             busy,
    output logic             done,
    output logic             overflow
);
    logic               chg_expire;
    logic               chg_run;
    logic               chg_load;
    logic               dis_clear;
    logic [NUM_DIS-1:0] dis_run;
    logic [NUM_DIS-1:0] dis_trip;
    logic [NUM_DIS-1:0] dis_full;
    logic [CNT_W-1:0]   dis_cnt [NUM_DIS];

    rcratio_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chg_expire (chg_expire),
        .trip       (dis_trip),
        .full       (dis_full),
        .sw_charge  (sw_charge),
        .sw_ref     (sw_ref),
        .sw_sense   (sw_sense),
        .busy       (busy),
        .done       (done),
        .overflow   (overflow),
        .chg_run    (chg_run),
        .chg_load   (chg_load),
        .dis_clear  (dis_clear),
        .dis_run    (dis_run)
    );

    rcratio_chg_timer #(.CHG_W(CHG_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (chg_load),
        .len_in (charge_len),
        .run    (chg_run),
        .expire (chg_expire)
    );

    for (genvar g = 0; g < NUM_DIS; g++) begin : g_dis
        rcratio_dis_count #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (dis_clear),
            .run       (dis_run[g]),
            .cmp_above (cmp_above),
            .count     (dis_cnt[g]),
            .trip      (dis_trip[g]),
            .full      (dis_full[g])
        );
    end

    assign ref_count   = dis_cnt[DIS_REF];
    assign sense_count = dis_cnt[DIS_SNS];
endmodule

// File: rtl/rcratio_seq_chk.sv
module rcratio_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cmp_above,
    input logic             sw_charge,
    input logic             sw_ref,
    input logic             sw_sense,
    input logic [CNT_W-1:0] ref_count,
    input logic [CNT_W-1:0] sense_count,
    input logic             busy,
    input logic             done,
    input logic             overflow
);
    logic [2:0] sw_vec;
    assign sw_vec = {sw_sense, sw_ref, sw_charge};

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && sw_charge));

    assert_one_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_vec) <= 1);

    assert_idle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_vec != 3'b000) |=> (sw_vec == $past(sw_vec) || sw_vec == 3'b000));

    assert_ref_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ref && !cmp_above) |=> !sw_ref);

    assert_sense_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sense && !cmp_above) |=> done);

    assert_no_overflow_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (!busy && !done));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ref_count) && $stable(sense_count)));
endmodule

bind rcratio_seq rcratio_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cmp_above   (cmp_above),
    .sw_charge   (sw_charge),
    .sw_ref      (sw_ref),
    .sw_sense    (sw_sense),
    .ref_count   (ref_count),
    .sense_count (sense_count),
    .busy        (busy),
    .done        (done),
    .overflow    (overflow)
);

// File: tb/rcratio_seq_test.sv
module rcratio_seq_test;
    localparam int CNT_W = 6;
    localparam int CHG_W = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CHG_W-1:0] charge_len = '0;
    logic             cmp_above = 1'b1;
    logic             sw_charge, sw_ref, sw_sense, busy, done, overflow;
    logic [CNT_W-1:0] ref_count, sense_count;

    int tests = 0;
    int failed = 0;
    int cycles = 0;
    int k_ref = 0;
    int k_sns = 0;
    int rn = 0;
    int sn = 0;
    int chg_seen, done_n, gap_bad, seq_code, cap_ref, cap_sns;
    logic [2:0] prev_sw;

    rcratio_seq #(.CNT_W(CNT_W), .CHG_W(CHG_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .charge_len(charge_len),
        .cmp_above(cmp_above), .sw_charge(sw_charge), .sw_ref(sw_ref),
        .sw_sense(sw_sense), .ref_count(ref_count), .sense_count(sense_count),
        .busy(busy), .done(done), .overflow(overflow)
    );

    always #4 clk = ~clk;

    // comparator model: stays above threshold for k discharge cycles
    always @(negedge clk) begin
        if (sw_ref) begin
            cmp_above <= (rn < k_ref);
            rn = rn + 1;
        end else if (sw_sense) begin
            cmp_above <= (sn < k_sns);
            sn = sn + 1;
        end else begin
            rn = 0;
            sn = 0;
            cmp_above <= 1'b1;
        end
    end

    // port monitor
    always @(negedge clk) begin
        logic [2:0] sw;
        sw = {sw_sense, sw_ref, sw_charge};
        if (sw_charge) chg_seen = chg_seen + 1;
        if (sw != 3'b000 && sw != prev_sw) seq_code = (seq_code << 3) | int'(sw);
        if (prev_sw != 3'b000 && sw != 3'b000 && sw != prev_sw) gap_bad = gap_bad + 1;
        prev_sw = sw;
        if (done) begin
            done_n  = done_n + 1;
            cap_ref = int'(ref_count);
            cap_sns = int'(sense_count);
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles == 190000) begin
            tests  = tests + 1;
            failed = failed + 1;
            $display("FAIL watchdog: act=%0d exp=%0d", cycles, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests = tests + 1;
        if (act != exp) begin
            failed = failed + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run(int chg, int kr, int ks, bit mid);
        int cyc;
        int eff;
        bit ovr, ovs;
        int e_ref, e_sns;
        k_ref = kr;
        k_sns = ks;
        charge_len = CHG_W'(chg);
        @(posedge clk);
        #1;
        chg_seen = 0; done_n = 0; gap_bad = 0; seq_code = 0;
        cap_ref = -1; cap_sns = -1; prev_sw = 3'b000;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        cyc = 0;
        while (busy && cyc < 3000) begin
            @(negedge clk);
            cyc = cyc + 1;
            if (mid && cyc == 3) begin
                start = 1'b1;           // R10: ignored while busy
                charge_len = CHG_W'(chg + 3); // R5: not sampled mid-run
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk("R2 busy drops at end", int'(busy), 0);
        eff = (chg == 0) ? 1 : chg;
        ovr = (kr > MAXC);
        ovs = !ovr && (ks > MAXC);
        e_ref = ovr ? MAXC : kr;
        e_sns = ovr ? 0 : (ovs ? MAXC : ks);
        chk("R6 ref_count", int'(ref_count), e_ref);
        chk("R7 sense_count", int'(sense_count), e_sns);
        chk("R5 charge cycles", chg_seen, ovr ? eff : 2 * eff);
        chk("R3 phase order", seq_code, ovr ? 32'h0A : 32'h28C);
        chk("R4 idle gap", gap_bad, 0);
        chk("R8 overflow flag", int'(overflow), int'(ovr || ovs));
        chk("R9 done pulses", done_n, (ovr || ovs) ? 0 : 1);
        if (!(ovr || ovs)) begin
            chk("R9 ref at done", cap_ref, e_ref);
            chk("R9 sense at done", cap_sns, e_sns);
        end
        repeat (4) @(negedge clk);
        chk("R9 ref stable", int'(ref_count), e_ref);
        chk("R9 sense stable", int'(sense_count), e_sns);
    endtask

    initial begin
        chg_seen = 0; done_n = 0; gap_bad = 0; seq_code = 0;
        cap_ref = 0; cap_sns = 0; prev_sw = 3'b000;
        repeat (3) @(negedge clk);
        chk("R1 switches in reset", int'({sw_sense, sw_ref, sw_charge}), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done/ovf after reset", int'({done, overflow}), 0);
        chk("R1 counts after reset", int'(ref_count) + int'(sense_count), 0);

        // near-exhaustive sweep
        foreach (charge_pick[i]) begin end
        for (int c = 0; c < 4; c++) begin
            for (int kr = 0; kr < 8; kr++) begin
                for (int ks = 0; ks < 8; ks++) begin
                    run((c == 3) ? 5 : c, kr, ks, 1'b0);
                end
            end
        end

        // limits: trip at maximum is valid, one beyond is overflow
        run(2, MAXC, 3, 1'b0);
        run(2, 4, MAXC, 1'b0);
        run(1, MAXC + 1, 3, 1'b0);   // R8 reference overflow
        run(1, 2, 2, 1'b0);          // R8 flag cleared by next start
        run(3, 5, MAXC + 1, 1'b0);   // R8 sensor overflow
        run(3, 200, 200, 1'b0);
        run(0, MAXC, MAXC, 1'b0);

        // R10 / R5: start and charge_len changes mid-sequence
        run(4, 6, 9, 1'b1);
        run(1, 0, 12, 1'b1);
        run(15, 3, 3, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    int charge_pick [1] = '{0};
endmodule